// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

This block is a down-counter that raises interrupt requests after a programmed number of prescaled ticks. Software programs three registers through a simple write port: a timer entry holding an 8-bit vector, a mask flag and a periodic flag; an initial count; and a divide setting. A read port returns any register, including the live current count. A clock-enable prescaler, set by the divide setting, paces each decrement.

When the count reaches zero and the entry is unmasked, the block offers a fixed-delivery, edge-style request carrying the entry's vector on a valid/ready output. The request stays offered with a stable vector until the consumer takes it. An expiry that lands while an earlier request still waits, and is not being taken in that same cycle, is merged into the waiting one and its vector is lost. In one-shot mode the count parks at zero. In periodic mode it reloads and runs again.

Top module: `tick_timer`

## Requirements
- R1: After reset the entry reads 0x0001_0000 (masked, one-shot, vector 0). The initial count, current count and divide setting read 0, and `req_valid` is low.
- R2: Register select: 0 = entry, 1 = initial count, 2 = current count, 3 = divide. A divide write keeps only bits 3, 1 and 0 (mask 0xB). An entry write keeps bits 7:0 (vector), 16 (mask) and 17 (periodic).
- R3: The divide code is {bit3, bit1, bit0}. The prescale shift is (code + 1) mod 8, and one tick occurs every 2^shift cycles. Code 7 ticks every cycle and code 0 ticks every second cycle.
- R4: An initial-count write sets the current count to the written value at that edge and restarts the prescaler. The first decrement comes 2^shift cycles later. A divide write also restarts the prescaler.
- R5: In one-shot mode the count falls to zero and stays there.
- R6: In periodic mode, a tick at zero reloads the initial count, so expiries come every initial-count-plus-one ticks.
- R7: An expiry is the tick that takes the count from 1 to 0. If the entry's mask bit was clear, `req_valid` rises at that edge with `req_vector` equal to the entry's vector. If the mask bit was set, no request is made.
- R8: An initial count of zero stops the timer. The count stays zero and no request is ever made, even in periodic mode.
- R9: Writes to the current-count register are ignored.
- R10: An entry write takes effect at the next tick. A one-shot timer parked at zero that is switched to periodic reloads on that next tick. A periodic timer switched to one-shot runs down to zero and stops.
- R11: A request holds `req_valid` and `req_vector` until a cycle with `req_ready` high. An expiry while a request waits and `req_ready` is low is dropped.
- R12: An initial-count write in the same cycle as an expiry tick wins. The count loads the new value and no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Register select for the read |
| rd_data | output | 32 | Read data (combinational) |
| req_valid | output | 1 | Interrupt request offered |
| req_ready | input | 1 | Consumer takes the request |
| req_vector | output | 8 | Vector of the offered request |

## Verification
Two functions can fall in the same cycle. The first pair is a count reload or expiry together with an initial-count write. The second pair is a fresh expiry together with the acceptance or stalling of a waiting request. The bench steers a one-shot count so that a rewrite lands exactly on the expiry tick, and it expects the new value and no request. It also runs a periodic count of one with `req_ready` held low, so that later expiries hit a waiting request, and it expects the first vector to stay in place until acceptance. Random register traffic and random back-pressure are then compared cycle by cycle against a bench model of the requirements.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int SEL_ENTRY = 0;
  localparam int SEL_INIT  = 1;
  localparam int SEL_CUR   = 2;
  localparam int SEL_DIV   = 3;

  localparam int MASK_POS  = 16;
  localparam int PER_POS   = 17;
  localparam int DIV_W     = 4;
  localparam logic [DIV_W-1:0] DIV_KEEP = 4'hB;
  localparam int CODE_W    = 3;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int PRE_W = (1 << CODE_W) - 1;

  logic [CODE_W-1:0] shift;
  logic [PRE_W-1:0]  pre_q;
  logic [PRE_W-1:0]  limit;

  // code + 1 wraps in CODE_W bits: the top code divides by one
  assign shift = code + CODE_W'(1);
  assign limit = PRE_W'((32'd1 << shift) - 32'd1);
  assign tick  = (pre_q & limit) == limit;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) pre_q <= '0;
    else                   pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             periodic,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic active;

  assign active = (reload_val != '0) && (periodic || count != '0);
  assign expire = tick && active && (count == CNT_W'(1)) && !load;

  always_ff @(posedge clk) begin
    if (!rst_n)              count <= '0;
    else if (load)           count <= load_val;
    else if (tick && active) count <= (count == '0) ? reload_val : count - CNT_W'(1);
  end
endmodule

// File: rtl/tt_req_out.sv
module tt_req_out #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [VEC_W-1:0] fire_vec,
  input  logic             ready,
  output logic             valid,
  output logic [VEC_W-1:0] vec
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      vec   <= '0;
    end else if (fire && (!valid || ready)) begin
      valid <= 1'b1;
      vec   <= fire_vec;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int VEC_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [VEC_W-1:0]  req_vector
);
  logic [VEC_W-1:0]  vec_q;
  logic              mask_q;
  logic              per_q;
  logic [CNT_W-1:0]  init_q;
  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  cur_cnt;
  logic [CODE_W-1:0] div_code;
  logic              wr_entry, wr_init, wr_div;
  logic              tick, expire;

  assign wr_entry = wr_en && (wr_addr == ADDR_W'(SEL_ENTRY));
  assign wr_init  = wr_en && (wr_addr == ADDR_W'(SEL_INIT));
  assign wr_div   = wr_en && (wr_addr == ADDR_W'(SEL_DIV));
  assign div_code = {div_q[3], div_q[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q  <= '0;
      mask_q <= 1'b1;
      per_q  <= 1'b0;
      init_q <= '0;
      div_q  <= '0;
    end else begin
      if (wr_entry) begin
        vec_q  <= wr_data[VEC_W-1:0];
        mask_q <= wr_data[MASK_POS];
        per_q  <= wr_data[PER_POS];
      end
      if (wr_init) init_q <= wr_data[CNT_W-1:0];
      if (wr_div)  div_q  <= wr_data[DIV_W-1:0] & DIV_KEEP;
    end
  end

  tt_prescaler #(.CODE_W(CODE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_init || wr_div),
    .code    (div_code),
    .tick    (tick)
  );

  tt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (wr_init),
    .load_val   (wr_data[CNT_W-1:0]),
    .reload_val (init_q),
    .periodic   (per_q),
    .tick       (tick),
    .count      (cur_cnt),
    .expire     (expire)
  );

  tt_req_out #(.VEC_W(VEC_W)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (expire && !mask_q),
    .fire_vec (vec_q),
    .ready    (req_ready),
    .valid    (req_valid),
    .vec      (req_vector)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(SEL_ENTRY): begin
        rd_data[VEC_W-1:0] = vec_q;
        rd_data[MASK_POS]  = mask_q;
        rd_data[PER_POS]   = per_q;
      end
      ADDR_W'(SEL_INIT): rd_data = DATA_W'(init_q);
      ADDR_W'(SEL_CUR):  rd_data = DATA_W'(cur_cnt);
      default:           rd_data = DATA_W'(div_q);
    endcase
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int VEC_W  = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              req_valid,
  input logic              req_ready,
  input logic [VEC_W-1:0]  req_vector,
  input logic              mask_i,
  input logic              per_i,
  input logic [CNT_W-1:0]  init_i,
  input logic [CNT_W-1:0]  cur_i
);
  logic init_wr;
  assign init_wr = wr_en && (wr_addr == ADDR_W'(SEL_INIT));

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !req_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_vector)));

  assert_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> !$past(mask_i));

  assert_zero_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (init_i == '0 && !init_wr) |=> (cur_i == '0));

  assert_oneshot_park_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_i && cur_i == '0 && !init_wr) |=> (cur_i == '0));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_vector (req_vector),
  .mask_i     (mask_q),
  .per_i      (per_q),
  .init_i     (init_q),
  .cur_i      (cur_cnt)
);

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = 2'd2;
  logic [31:0] rd_data;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic [7:0]  req_vector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  logic [7:0]  m_vec;
  logic        m_mask, m_per;
  logic [31:0] m_init, m_cur;
  logic [3:0]  m_div;
  logic [6:0]  m_pre;
  logic        m_valid;
  logic [7:0]  m_vvec;

  always #4 clk = ~clk;

  tick_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .req_valid(req_valid),
    .req_ready(req_ready), .req_vector(req_vector)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_vec = '0; m_mask = 1'b1; m_per = 1'b0; m_init = '0; m_cur = '0;
    m_div = '0; m_pre = '0; m_valid = 1'b0; m_vvec = '0;
  endtask

  task automatic model_edge(input bit we, input logic [1:0] a, input logic [31:0] d, input bit rdy);
    logic [2:0] shift;
    logic [6:0] limit;
    bit tick, active, exp, winit, wdiv;
    shift  = {m_div[3], m_div[1:0]} + 3'd1;
    limit  = 7'((32'd1 << shift) - 32'd1);
    tick   = (m_pre & limit) == limit;
    winit  = we && a == 2'd1;
    wdiv   = we && a == 2'd3;
    active = (m_init != 0) && (m_per || m_cur != 0);
    exp    = tick && active && m_cur == 32'd1 && !winit;
    if (exp && !m_mask && (!m_valid || rdy)) begin
      m_valid = 1'b1; m_vvec = m_vec;
    end else if (m_valid && rdy) m_valid = 1'b0;
    if (winit)                m_cur = d;
    else if (tick && active)  m_cur = (m_cur == 0) ? m_init : m_cur - 32'd1;
    m_pre = (winit || wdiv) ? 7'd0 : m_pre + 7'd1;
    if (we && a == 2'd0) begin m_vec = d[7:0]; m_mask = d[16]; m_per = d[17]; end
    if (winit) m_init = d;
    if (wdiv)  m_div = d[3:0] & 4'hB;
  endtask

  task automatic step(input bit we, input logic [1:0] a, input logic [31:0] d, input bit rdy);
    wr_en = we; wr_addr = a; wr_data = d; req_ready = rdy; rd_addr = 2'd2;
    @(posedge clk);
    model_edge(we, a, d, rdy);
    @(negedge clk);
    wr_en = 1'b0;
    chk(rd_data == m_cur, "R4 R5 R6 model current count", rd_data, m_cur);
    chk(req_valid == m_valid, "R11 model req_valid", 32'(req_valid), 32'(m_valid));
    if (m_valid) chk(req_vector == m_vvec, "R7 model req_vector", 32'(req_vector), 32'(m_vvec));
  endtask

  task automatic idle(input int n, input bit rdy);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 32'd0, rdy);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_addr = a; #1; v = rd_data; rd_addr = 2'd2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int pulses;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk(v == 32'h0001_0000, "R1 entry reset", v, 32'h0001_0000);
    rd(2'd1, v); chk(v == 0, "R1 init reset", v, 0);
    rd(2'd2, v); chk(v == 0, "R1 cur reset", v, 0);
    rd(2'd3, v); chk(v == 0, "R1 div reset", v, 0);
    chk(req_valid == 1'b0, "R1 req_valid reset", 32'(req_valid), 0);

    // R2 field keeping
    step(1'b1, 2'd3, 32'hFFFF_FFFF, 1'b1);
    rd(2'd3, v); chk(v == 32'hB, "R2 divide keeps bits 3,1,0", v, 32'hB);
    step(1'b1, 2'd0, 32'hFFFF_FF41, 1'b1);
    rd(2'd0, v); chk(v == 32'h0003_0041, "R2 entry keeps fields", v, 32'h0003_0041);

    // one-shot, divide by 1, held request
    step(1'b1, 2'd0, 32'h0000_0041, 1'b1);
    step(1'b1, 2'd1, 32'd4, 1'b0);
    chk(rd_data == 4, "R4 load at write edge", rd_data, 4);
    idle(1, 1'b0);
    chk(rd_data == 3, "R3 code 7 ticks every cycle", rd_data, 3);
    idle(3, 1'b0);
    chk(rd_data == 0 && req_valid, "R7 expiry raises request", {31'd0, req_valid}, 1);
    chk(req_vector == 8'h41, "R7 vector", 32'(req_vector), 32'h41);
    idle(3, 1'b0);
    chk(rd_data == 0, "R5 one-shot stays at zero", rd_data, 0);
    chk(req_valid && req_vector == 8'h41, "R11 request held", 32'(req_vector), 32'h41);
    idle(1, 1'b1);
    chk(!req_valid, "R11 request taken", 32'(req_valid), 0);

    // R3 divide by 2
    step(1'b1, 2'd3, 32'h0, 1'b1);
    step(1'b1, 2'd1, 32'd3, 1'b1);
    idle(1, 1'b1);
    chk(rd_data == 3, "R3 code 0 no tick on first cycle", rd_data, 3);
    idle(1, 1'b1);
    chk(rd_data == 2, "R3 code 0 ticks every second cycle", rd_data, 2);

    // R8 zero initial count in periodic mode
    step(1'b1, 2'd0, 32'h0002_0041, 1'b1);
    step(1'b1, 2'd1, 32'd0, 1'b1);
    pulses = 0;
    for (int i = 0; i < 10; i++) begin idle(1, 1'b1); if (req_valid) pulses++; end
    chk(pulses == 0 && rd_data == 0, "R8 zero count stops timer", 32'(pulses), 0);

    // R6 periodic
    step(1'b1, 2'd3, 32'hB, 1'b1);
    step(1'b1, 2'd0, 32'h0002_0022, 1'b1);
    step(1'b1, 2'd1, 32'd2, 1'b1);
    pulses = 0;
    for (int i = 0; i < 9; i++) begin
      idle(1, 1'b1);
      if (req_valid) begin
        pulses++;
        chk(req_vector == 8'h22, "R6 periodic vector", 32'(req_vector), 32'h22);
      end
    end
    chk(pulses == 3, "R6 three expiries in nine ticks", 32'(pulses), 3);
    chk(rd_data == 2, "R6 reloaded count", rd_data, 2);

    // R9 current count is read-only
    step(1'b1, 2'd1, 32'd10, 1'b1);
    step(1'b1, 2'd2, 32'd99, 1'b1);
    chk(rd_data == 9, "R9 current count write ignored", rd_data, 9);
    idle(1, 1'b1);
    chk(rd_data == 8, "R9 count continues", rd_data, 8);

    // R7 masked expiry
    step(1'b1, 2'd0, 32'h0001_0033, 1'b1);
    step(1'b1, 2'd1, 32'd2, 1'b1);
    pulses = 0;
    for (int i = 0; i < 5; i++) begin idle(1, 1'b1); if (req_valid) pulses++; end
    chk(pulses == 0 && rd_data == 0, "R7 masked expiry gives no request", 32'(pulses), 0);

    // R10 entry rewrite
    step(1'b1, 2'd0, 32'h0000_0044, 1'b1);
    step(1'b1, 2'd0, 32'h0002_0044, 1'b1);
    chk(rd_data == 0, "R10 parked before switch applies", rd_data, 0);
    idle(1, 1'b1);
    chk(rd_data == 2, "R10 switch to periodic reloads", rd_data, 2);
    step(1'b1, 2'd0, 32'h0000_0044, 1'b1);
    idle(1, 1'b1);
    chk(rd_data == 0 && req_valid, "R10 switch to one-shot runs down", rd_data, 0);
    idle(2, 1'b1);
    chk(rd_data == 0 && !req_valid, "R10 one-shot stops", rd_data, 0);

    // R12 write on the expiry tick
    step(1'b1, 2'd1, 32'd2, 1'b1);
    idle(1, 1'b1);
    step(1'b1, 2'd1, 32'd5, 1'b1);
    chk(rd_data == 5 && !req_valid, "R12 write beats expiry", {31'd0, req_valid}, 0);
    step(1'b1, 2'd1, 32'd0, 1'b1);

    // R11 expiry dropped while waiting
    step(1'b1, 2'd0, 32'h0002_0055, 1'b0);
    step(1'b1, 2'd1, 32'd1, 1'b0);
    idle(1, 1'b0);
    chk(req_valid && req_vector == 8'h55, "R11 first request", 32'(req_vector), 32'h55);
    step(1'b1, 2'd0, 32'h0002_0066, 1'b0);
    idle(1, 1'b0);
    chk(req_valid && req_vector == 8'h55, "R11 later expiry dropped", 32'(req_vector), 32'h55);
    idle(1, 1'b1);
    chk(!req_valid, "R11 taken", 32'(req_valid), 0);
    idle(1, 1'b1);
    chk(req_valid && req_vector == 8'h66, "R11 next request new vector", 32'(req_vector), 32'h66);
    step(1'b1, 2'd1, 32'd0, 1'b1);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      bit rdy;
      logic [31:0] d;
      r   = int'($urandom % 16);
      rdy = ($urandom % 4) != 0;
      case (r)
        0, 1: begin
          d = ($urandom % 8 == 0) ? 32'd0 : ($urandom % 12) + 1;
          step(1'b1, 2'd1, d, rdy);
        end
        2: begin
          d = ($urandom & 32'h0003_00FF) | ($urandom & 32'hFFFC_FF00);
          step(1'b1, 2'd0, d, rdy);
        end
        3: begin
          case ($urandom % 4)
            0: d = 32'hB;
            1: d = 32'h0;
            2: d = 32'h1;
            default: d = 32'hFFFF_FFF0 | 32'h8;
          endcase
          step(1'b1, 2'd3, d, rdy);
        end
        4: step(1'b1, 2'd2, $urandom, rdy);
        default: step(1'b0, 2'd0, 32'd0, rdy);
      endcase
    end

    finish_run();
  end
endmodule